// File: doc/BRIEF.md
# Eight-bit ALU with carry and zero flags

This block is the datapath arithmetic unit of a small accumulator-style soft processor. Each cycle it takes a destination operand, a second operand (a register value or an immediate, chosen before the block), and a 4-bit operation code. It produces the result combinationally in the same cycle. Two status flags, carry and zero, sit in registers inside the block. They are written on the rising clock edge when the flag write enable is high. Branch logic reads the zero flag. Carry-chained add, subtract and rotate read the carry flag.

The unit has add, subtract, add with carry in, and subtract with borrow from carry. It also has AND, OR and XOR, three one-bit right shifts, and a nibble swap. The three right shifts differ only in what enters the top bit: the carry flag, a zero, or the old top bit. There is no compare and no left shift. Software compares by subtracting with the flag write enable set. It shifts left by adding an operand to itself.

Operand handling is plain and single-cycle. There is no valid/ready handshake, because the processor decides in each cycle whether the flags are written. The result is always a pure function of the present inputs and the stored carry.

Top module: `alu8_core`

## Requirements
- R1: Code 0 (add) gives result = A + B. Code 1 (add with carry) gives A + B + C, where C is the stored carry flag. For both, the carry-out of the top bit is the new carry.
- R2: Code 2 (subtract) gives A − B. Code 3 (subtract with borrow) gives A − B − (1 − C). For both, the new carry is 1 when no borrow occurred; for code 2 this means A ≥ B unsigned.
- R3: Codes 4, 5 and 6 give A AND B, A OR B and A XOR B. These codes leave the carry flag unchanged.
- R4: Code 7 (rotate through carry) gives A shifted right by one, with the stored carry entering bit 7.
- R5: Code 8 (logical shift) gives A shifted right by one, with bit 7 forced to 0.
- R6: Code 9 (arithmetic shift) gives A shifted right by one, with bit 7 keeping A's old bit 7.
- R7: Codes 7, 8 and 9 write A's bit 0 into the carry flag.
- R8: Code 10 (swap) gives {A[3:0], A[7:4]}. It leaves the carry flag unchanged.
- R9: For codes 0 to 10, the zero flag becomes 1 exactly when the result is 0.
- R10: The flags change only on a rising clock edge with the flag write enable at 1. With the enable at 0, both flags hold their values.
- R11: An active-low reset clears the carry and zero flags.
- R12: Codes 11 to 15 pass A to the result unchanged. They leave both flags unchanged, even with the enable at 1.
- R13: Adding an operand to itself shifts it left by one, with the old bit 7 going to carry. Subtracting with the enable set acts as a compare: the carry shows A ≥ B and the zero flag shows A = B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flags update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_a | input | 8 | Destination operand |
| op_b | input | 8 | Second operand (register or immediate) |
| op_sel | input | 4 | Operation code |
| flag_we | input | 1 | Flag write enable |
| result | output | 8 | Combinational result |
| carry_o | output | 1 | Stored carry flag |
| zero_o | output | 1 | Stored zero flag |

## Verification
The hardest cases depend on the stored carry from an earlier operation. These are subtract with borrow, add with carry and rotate through carry, and they must be checked with both carry values. In particular, subtract with borrow must be checked with equal operands and carry clear, where it wraps to all ones and signals a borrow. The stimulus first runs a directed operation that sets or clears the carry, then issues the chained operation. A long random run with a random flag write enable follows. It mixes carry-setting and carry-reading codes, so each chained code is reached from both carry values and also with a held flag.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_RTC  = 4'd7,
    OP_SHRL = 4'd8,
    OP_SHRA = 4'd9,
    OP_NSWP = 4'd10
  } alu_op_e;

  localparam int unsigned LAST_DEFINED = 10;

  function automatic logic op_is_shift(input logic [3:0] op);
    return (op == OP_RTC) || (op == OP_SHRL) || (op == OP_SHRA);
  endfunction

  function automatic logic op_is_arith(input logic [3:0] op);
    return op <= OP_SBC;
  endfunction

  function automatic logic op_is_defined(input logic [3:0] op);
    return 32'(op) <= LAST_DEFINED;
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         subtract,
  input  logic         chain,
  input  logic         carry_in,
  output logic [W-1:0] sum,
  output logic         carry_out
);
  logic [W-1:0] b_eff;
  logic [W:0]   c;

  assign b_eff = subtract ? ~b : b;
  // Without chaining, a subtract injects +1 (two's complement), an add injects 0.
  assign c[0]  = chain ? carry_in : subtract;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i]   = a[i] ^ b_eff[i] ^ c[i];
    assign c[i+1]   = (a[i] & b_eff[i]) | (c[i] & (a[i] ^ b_eff[i]));
  end

  assign carry_out = c[W];
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [1:0]   fill_sel,   // 0: carry, 1: zero, 2: old top bit, 3: swap halves
  input  logic         carry_in,
  output logic [W-1:0] res,
  output logic         shifted_out
);
  localparam int HALF = W / 2;

  logic         top_fill;
  logic [W-1:0] swapped;

  always_comb begin
    unique case (fill_sel)
      2'd0:    top_fill = carry_in;
      2'd1:    top_fill = 1'b0;
      default: top_fill = a[W-1];
    endcase
  end

  for (genvar i = 0; i < HALF; i++) begin : g_swap
    assign swapped[i]        = a[i + HALF];
    assign swapped[i + HALF] = a[i];
  end

  assign res         = (fill_sel == 2'd3) ? swapped : {top_fill, a[W-1:1]};
  assign shifted_out = a[0];
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic carry_upd,
  input  logic zero_upd,
  input  logic carry_nxt,
  input  logic zero_nxt,
  output logic carry_q,
  output logic zero_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else if (we) begin
      if (carry_upd) carry_q <= carry_nxt;
      if (zero_upd)  zero_q  <= zero_nxt;
    end
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   op_sel,
  input  logic         flag_we,
  output logic [W-1:0] result,
  output logic         carry_o,
  output logic         zero_o
);
  logic [W-1:0] arith_res, shift_res, logic_res;
  logic         arith_cout, shift_cout;
  logic [1:0]   fill_sel;
  logic         c_upd, z_upd, c_nxt;

  alu8_addsub #(.W(W)) i_addsub (
    .a(op_a), .b(op_b),
    .subtract(op_sel == OP_SUB || op_sel == OP_SBC),
    .chain(op_sel == OP_ADC || op_sel == OP_SBC),
    .carry_in(carry_o),
    .sum(arith_res), .carry_out(arith_cout)
  );

  always_comb begin
    unique case (op_sel)
      OP_RTC:  fill_sel = 2'd0;
      OP_SHRL: fill_sel = 2'd1;
      OP_SHRA: fill_sel = 2'd2;
      default: fill_sel = 2'd3;
    endcase
  end

  alu8_shifter #(.W(W)) i_shifter (
    .a(op_a), .fill_sel(fill_sel), .carry_in(carry_o),
    .res(shift_res), .shifted_out(shift_cout)
  );

  always_comb begin
    unique case (op_sel)
      OP_AND:  logic_res = op_a & op_b;
      OP_OR:   logic_res = op_a | op_b;
      default: logic_res = op_a ^ op_b;
    endcase
  end

  always_comb begin
    if (op_is_arith(op_sel))                          result = arith_res;
    else if (op_sel >= OP_AND && op_sel <= OP_XOR)    result = logic_res;
    else if (op_is_defined(op_sel))                   result = shift_res;
    else                                              result = op_a;
  end

  assign c_upd = op_is_arith(op_sel) || op_is_shift(op_sel);
  assign z_upd = op_is_defined(op_sel);
  assign c_nxt = op_is_arith(op_sel) ? arith_cout : shift_cout;

  alu8_flags i_flags (
    .clk(clk), .rst_n(rst_n), .we(flag_we),
    .carry_upd(c_upd), .zero_upd(z_upd),
    .carry_nxt(c_nxt), .zero_nxt(result == '0),
    .carry_q(carry_o), .zero_q(zero_o)
  );

  a_r10_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(carry_o) && $stable(zero_o));

  a_r7_shift_carry: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we && op_is_shift(op_sel) |=> carry_o == $past(op_a[0]));

  a_r9_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we && op_is_defined(op_sel) |=> zero_o == ($past(result) == '0));

  a_r12_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_is_defined(op_sel) |=> $stable(carry_o) && $stable(zero_o));

  a_r3_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel >= OP_AND && op_sel <= OP_XOR) |=> $stable(carry_o));

  a_r2_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we && op_sel == OP_SUB |=> carry_o == ($past(op_a) >= $past(op_b)));
endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] op_a = '0, op_b = '0;
  logic [3:0] op_sel = '0;
  logic       flag_we = 1'b0;
  logic [7:0] result;
  logic       carry_o, zero_o;

  int n_checks = 0;
  int n_fail = 0;
  bit m_c = 0, m_z = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core i_alu8_core (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .flag_we(flag_we), .result(result), .carry_o(carry_o), .zero_o(zero_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (op=%0d a=%0h b=%0h)",
               req, act, exp, op_sel, op_a, op_b);
    end
  endtask

  function automatic string res_tag(input int op);
    case (op)
      0, 1: return "R1";
      2, 3: return "R2";
      4, 5, 6: return "R3";
      7: return "R4";
      8: return "R5";
      9: return "R6";
      10: return "R8";
      default: return "R12";
    endcase
  endfunction

  // Behavioural reference: returns result, updates model flags when written.
  task automatic step(input int a, input int b, input int op, input bit we, input string tag = "");
    int r, s;
    bit nc, uc, uz;
    @(negedge clk);
    op_a = a[7:0]; op_b = b[7:0]; op_sel = op[3:0]; flag_we = we;
    uc = 0; uz = (op <= 10); nc = m_c;
    case (op)
      0: begin s = a + b;                 r = s & 255; nc = s[8]; uc = 1; end
      1: begin s = a + b + int'(m_c);     r = s & 255; nc = s[8]; uc = 1; end
      2: begin s = a - b;                 r = s & 255; nc = (s >= 0); uc = 1; end
      3: begin s = a - b - int'(!m_c);    r = s & 255; nc = (s >= 0); uc = 1; end
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: begin r = (a >> 1) | (int'(m_c) << 7); nc = a[0]; uc = 1; end
      8: begin r = a >> 1;                       nc = a[0]; uc = 1; end
      9: begin r = (a >> 1) | (a & 128);         nc = a[0]; uc = 1; end
      10: r = ((a << 4) | (a >> 4)) & 255;
      default: r = a;
    endcase
    #1;
    check(tag != "" ? tag : res_tag(op), int'(result), r);
    @(posedge clk);
    if (we) begin
      if (uc) m_c = nc;
      if (uz) m_z = (r == 0);
    end
    #1;
    if (tag != "") begin
      check(tag, int'(carry_o), int'(m_c));
      check(tag, int'(zero_o), int'(m_z));
    end else if (!we) begin
      check("R10", int'(carry_o), int'(m_c));
      check("R10", int'(zero_o), int'(m_z));
    end else if (op > 10) begin
      check("R12", int'(carry_o), int'(m_c));
      check("R12", int'(zero_o), int'(m_z));
    end else begin
      check(op >= 7 && op <= 9 ? "R7" : (op >= 4 ? "R3" : res_tag(op)),
            int'(carry_o), int'(m_c));
      check("R9", int'(zero_o), int'(m_z));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11", int'(carry_o), 0);
    check("R11", int'(zero_o), 0);
    @(negedge clk); rst_n = 1'b1;

    step(8'hF0, 8'h20, 0, 1);            // R1 carry out
    step(8'h01, 8'h01, 1, 1);            // R1 adc with carry set
    step(8'h05, 8'h05, 2, 1);            // R2 equal, carry=1 zero=1
    step(8'h05, 8'h05, 3, 1);            // R2 sbc with carry set
    step(8'h03, 8'h04, 2, 1);            // R2 borrow, carry=0
    step(8'h05, 8'h05, 3, 1);            // R2 sbc wraps to FF with carry clear
    step(8'h0F, 8'hF0, 4, 1);            // R3 and -> zero, carry kept
    step(8'h81, 8'h00, 8, 1);            // R5, R7
    step(8'h80, 8'h00, 7, 1);            // R4 carry 1 enters bit 7
    step(8'h81, 8'h00, 9, 1);            // R6
    step(8'hA5, 8'h00, 10, 1);           // R8
    step(8'h00, 8'h00, 10, 1);           // R9 swap of zero
    step(8'h3C, 8'h11, 12, 1);           // R12
    step(8'h00, 8'h00, 0, 0);            // R10 disabled
    step(8'hC1, 8'hC1, 0, 1, "R13");     // left shift by self-add
    step(8'h40, 8'h40, 2, 1, "R13");     // compare equal
    step(8'h10, 8'h40, 2, 1, "R13");     // compare less

    for (int i = 0; i < 3000; i++)
      step(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 15)), bit'($urandom_range(0, 3) != 0));

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule